// File: doc/BRIEF.md
# Operand Address-Vector Prefix Parser

This block sits in an instruction decoder, ahead of the operation byte. It reads a run of operand prefix bytes, one byte per cycle, and turns them into a memory operand descriptor. The descriptor holds a base register, up to two index registers with scale factors, a decimal displacement, and an optional delegate (link) register number. A delegate means that the real descriptor lives at the address held in that link register.

Each prefix byte has two parts. Its high nibble names a register pair and its low nibble supplies the next decimal displacement digit. Naming a register that is already present raises that register's scale instead of adding a new term. Pairs of identical bytes at the start of the run spell out a delegate number, one decimal digit per pair.

When the first non-prefix byte arrives, the block ends the run. It publishes the descriptor together with that terminating byte and gives a one-cycle completion pulse. The published fields then stay fixed until the next run ends. Address arithmetic, register reads and the remote fetch through the delegate are done elsewhere.

Top module: `opv_parser`

## Requirements
- R1: A byte is a prefix when its high nibble is 1..9 and its low nibble is 0..9. Any other valid byte ends the run. `done_o` is high for exactly the cycle after the clock edge that accepts the terminating byte, and `op_o` then equals that byte.
- R2: The first prefix byte that is not part of a delegate pair sets `base_o` to its high nibble and sets `base_v_o`. Its low nibble is the first displacement digit.
- R3: The low nibbles of all address bytes (the base byte and the bytes after it) are joined in order as one decimal number. `disp_o` gives that number in binary, so leading zeros have no effect.
- R4: Each new register that is neither the base nor an existing index takes the first free index slot (slot 0, then slot 1) with scale 1. The two index registers are always distinct from each other and from the base.
- R5: Naming an existing index register again adds 1 to its scale. Scales saturate at 15.
- R6: Naming the base register again adds 1 to the scale of the index register named most recently. If no index exists yet, this raises `err_o`.
- R7: A third distinct index register raises `err_o` and changes no slot. Its displacement digit is still appended.
- R8: A digit that would push the displacement above 999999 raises `err_o`, and the displacement keeps its previous value.
- R9: Before any base is set, two identical consecutive prefix bytes form one delegate digit, equal to their high nibble. The digits are joined in decimal into `dlg_o`, and `dlg_v_o` is set.
- R10: A delegate followed directly by the terminating byte reports `dlg_v_o`=1, `base_v_o`=0 and `dbl_o`=0.
- R11: A delegate followed by further address bytes reports `dbl_o`=1, together with the decoded base, indexes and displacement.
- R12: After reset every output is zero. Between completion pulses, and during cycles with `in_valid`=0, all outputs hold their values.
- R13: A delegate digit that would push `dlg_o` above 999 raises `err_o`, and `dlg_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_byte | input | 8 | Offered byte |
| done_o | output | 1 | One-cycle pulse: descriptor published |
| op_o | output | 8 | Terminating byte of the last run |
| base_v_o | output | 1 | Base register present |
| base_o | output | 4 | Base register number |
| idx0_v_o | output | 1 | Index slot 0 in use |
| idx0_o | output | 4 | Index slot 0 register |
| scl0_o | output | 4 | Index slot 0 scale |
| idx1_v_o | output | 1 | Index slot 1 in use |
| idx1_o | output | 4 | Index slot 1 register |
| scl1_o | output | 4 | Index slot 1 scale |
| disp_o | output | 24 | Displacement, binary |
| dlg_v_o | output | 1 | Delegate reference present |
| dlg_o | output | 10 | Delegate link register number |
| dbl_o | output | 1 | Delegate plus immediate address bytes |
| err_o | output | 1 | Malformed vector |

## Verification
Some properties are checked by assertions on every cycle:
- a terminating byte always leads to a completion pulse;
- published fields never change outside a pulse;
- the displacement and the delegate number stay within their decimal limits;
- index slots stay distinct from each other and from the base;
- the double-pointer flag appears only together with both a delegate and a base.

Other behaviour only the bench scenarios can show. This covers the values themselves: the scale reached through base-repeat markers and through saturation, the joined displacement digits, the delegate number built from byte pairs, and the point at which a held lead byte becomes the base rather than half of a delegate pair.

// File: rtl/opv_pkg.sv
package opv_pkg;
  localparam int DISP_W  = 24;
  localparam int SCL_W   = 4;
  localparam int DLG_W   = 10;
  localparam int REG_W   = 4;
  localparam int SCL_MAX = (1 << SCL_W) - 1;

  typedef struct packed {
    logic              base_v;
    logic [REG_W-1:0]  base;
    logic [1:0]        n;      // index slots in use
    logic [REG_W-1:0]  idx0;
    logic [SCL_W-1:0]  scl0;
    logic [REG_W-1:0]  idx1;
    logic [SCL_W-1:0]  scl1;
    logic              last;   // slot named most recently
    logic [DISP_W-1:0] disp;
    logic              err;
  } vec_t;

  function automatic logic [SCL_W-1:0] scl_bump(logic [SCL_W-1:0] s);
    return (s == SCL_W'(SCL_MAX)) ? s : s + 1'b1;
  endfunction

  function automatic vec_t vec_start(logic [REG_W-1:0] hi, logic [3:0] lo);
    vec_t v;
    v        = '0;
    v.base_v = 1'b1;
    v.base   = hi;
    v.disp   = DISP_W'(lo);
    return v;
  endfunction

  // Folds one address byte (after the base) into the vector.
  function automatic vec_t vec_term(vec_t v, logic [REG_W-1:0] hi, logic [3:0] lo,
                                    int unsigned disp_max);
    vec_t nv;
    logic [DISP_W+3:0] nd;
    nv = v;
    nd = (DISP_W+4)'(v.disp) * (DISP_W+4)'(10) + (DISP_W+4)'(lo);
    if (nd > (DISP_W+4)'(disp_max)) nv.err = 1'b1;
    else                            nv.disp = nd[DISP_W-1:0];
    if (hi == v.base) begin
      if (v.n == 2'd0)     nv.err  = 1'b1;
      else if (v.last)     nv.scl1 = scl_bump(v.scl1);
      else                 nv.scl0 = scl_bump(v.scl0);
    end else if (v.n != 2'd0 && hi == v.idx0) begin
      nv.scl0 = scl_bump(v.scl0);
      nv.last = 1'b0;
    end else if (v.n == 2'd2 && hi == v.idx1) begin
      nv.scl1 = scl_bump(v.scl1);
      nv.last = 1'b1;
    end else if (v.n == 2'd0) begin
      nv.idx0 = hi; nv.scl0 = SCL_W'(1); nv.n = 2'd1; nv.last = 1'b0;
    end else if (v.n == 2'd1) begin
      nv.idx1 = hi; nv.scl1 = SCL_W'(1); nv.n = 2'd2; nv.last = 1'b1;
    end else begin
      nv.err = 1'b1;
    end
    return nv;
  endfunction
endpackage

// File: rtl/opv_class.sv
module opv_class
  import opv_pkg::*;
(
  input  logic [7:0]       byte_i,
  output logic             pre_o,
  output logic [REG_W-1:0] hi_o,
  output logic [3:0]       lo_o
);
  assign hi_o  = byte_i[7:4];
  assign lo_o  = byte_i[3:0];
  assign pre_o = (byte_i[7:4] >= 4'd1) && (byte_i[7:4] <= 4'd9) && (byte_i[3:0] <= 4'd9);
endmodule

// File: rtl/opv_dlg_acc.sv
module opv_dlg_acc #(
  parameter int W   = 10,
  parameter int MAX = 999
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [3:0]   digit,
  output logic [W-1:0] idx_o,
  output logic         v_o,
  output logic         err_o
);
  logic [W+3:0] nx;
  assign nx = (W+4)'(idx_o) * (W+4)'(10) + (W+4)'(digit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idx_o <= '0;
      v_o   <= 1'b0;
      err_o <= 1'b0;
    end else if (push) begin
      v_o <= 1'b1;
      if (nx > (W+4)'(MAX)) err_o <= 1'b1;
      else                  idx_o <= nx[W-1:0];
    end
  end

  AST_DLG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o <= W'(MAX)); // R13
endmodule

// File: rtl/opv_parser.sv
module opv_parser
  import opv_pkg::*;
#(
  parameter int DISP_MAX = 999999,
  parameter int DLG_MAX  = 999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              done_o,
  output logic [7:0]        op_o,
  output logic              base_v_o,
  output logic [REG_W-1:0]  base_o,
  output logic              idx0_v_o,
  output logic [REG_W-1:0]  idx0_o,
  output logic [SCL_W-1:0]  scl0_o,
  output logic              idx1_v_o,
  output logic [REG_W-1:0]  idx1_o,
  output logic [SCL_W-1:0]  scl1_o,
  output logic [DISP_W-1:0] disp_o,
  output logic              dlg_v_o,
  output logic [DLG_W-1:0]  dlg_o,
  output logic              dbl_o,
  output logic              err_o
);
  localparam int NCLS = 2; // 0: incoming byte, 1: held lead byte

  vec_t             vec_q, vec_a, vec_b;
  logic             held_v;
  logic [7:0]       held_b;
  logic [7:0]       cls_b   [NCLS];
  logic             cls_pre [NCLS];
  logic [REG_W-1:0] cls_hi  [NCLS];
  logic [3:0]       cls_lo  [NCLS];

  assign cls_b[0] = in_byte;
  assign cls_b[1] = held_b;

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    opv_class u_cls (
      .byte_i (cls_b[g]),
      .pre_o  (cls_pre[g]),
      .hi_o   (cls_hi[g]),
      .lo_o   (cls_lo[g])
    );
  end

  // Named events
  logic lead, same_b, ev_term, ev_dlg_push, ev_commit, ev_apply, ev_hold;
  assign lead        = !vec_q.base_v;
  assign same_b      = (in_byte == held_b);
  assign ev_term     = in_valid && !cls_pre[0];
  assign ev_dlg_push = in_valid && cls_pre[0] && lead && held_v && same_b;
  assign ev_commit   = in_valid && lead && held_v && cls_pre[1] && !(cls_pre[0] && same_b);
  assign ev_apply    = in_valid && cls_pre[0] && (!lead || ev_commit);
  assign ev_hold     = in_valid && cls_pre[0] && lead && !held_v;

  always_comb begin
    vec_a = ev_commit ? vec_start(cls_hi[1], cls_lo[1]) : vec_q;
    vec_b = ev_apply  ? vec_term(vec_a, cls_hi[0], cls_lo[0], DISP_MAX) : vec_a;
  end

  logic [DLG_W-1:0] dlg_idx;
  logic             dlg_v, dlg_err;

  opv_dlg_acc #(.W(DLG_W), .MAX(DLG_MAX)) u_dlg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_term),
    .push  (ev_dlg_push),
    .digit (cls_hi[1]),
    .idx_o (dlg_idx),
    .v_o   (dlg_v),
    .err_o (dlg_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      held_v <= 1'b0;
      held_b <= '0;
    end else begin
      vec_q <= ev_term ? '0 : vec_b;
      if (ev_term || ev_dlg_push || ev_commit) held_v <= 1'b0;
      else if (ev_hold) begin
        held_v <= 1'b1;
        held_b <= in_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0; op_o <= '0;
      base_v_o <= 1'b0; base_o <= '0;
      idx0_v_o <= 1'b0; idx0_o <= '0; scl0_o <= '0;
      idx1_v_o <= 1'b0; idx1_o <= '0; scl1_o <= '0;
      disp_o <= '0; dlg_v_o <= 1'b0; dlg_o <= '0;
      dbl_o <= 1'b0; err_o <= 1'b0;
    end else begin
      done_o <= ev_term;
      if (ev_term) begin
        op_o     <= in_byte;
        base_v_o <= vec_b.base_v;
        base_o   <= vec_b.base;
        idx0_v_o <= (vec_b.n != 2'd0);
        idx0_o   <= vec_b.idx0;
        scl0_o   <= vec_b.scl0;
        idx1_v_o <= (vec_b.n == 2'd2);
        idx1_o   <= vec_b.idx1;
        scl1_o   <= vec_b.scl1;
        disp_o   <= vec_b.disp;
        dlg_v_o  <= dlg_v;
        dlg_o    <= dlg_idx;
        dbl_o    <= dlg_v && vec_b.base_v;
        err_o    <= vec_b.err || dlg_err;
      end
    end
  end

  AST_TERM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cls_pre[0]) |=> done_o); // R1
  AST_DISP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (disp_o <= DISP_W'(DISP_MAX))); // R8
  AST_IDX_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && idx1_v_o) |-> (idx0_v_o && idx1_o != idx0_o && idx0_o != base_o)); // R4
  AST_SCALE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && idx0_v_o) |-> (scl0_o != '0)); // R5
  AST_DBL_NEEDS_DLG: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_o |-> (dlg_v_o && base_v_o)); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(disp_o) && $stable(base_o) && $stable(dlg_o) && $stable(op_o))); // R12
endmodule

// File: tb/opv_parser_tb.sv
module opv_parser_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;

  logic done_o, base_v_o, idx0_v_o, idx1_v_o, dlg_v_o, dbl_o, err_o;
  logic [7:0] op_o;
  logic [3:0] base_o, idx0_o, scl0_o, idx1_o, scl1_o;
  logic [23:0] disp_o;
  logic [9:0] dlg_o;

  always #5 clk = ~clk;

  opv_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .done_o(done_o), .op_o(op_o), .base_v_o(base_v_o), .base_o(base_o),
    .idx0_v_o(idx0_v_o), .idx0_o(idx0_o), .scl0_o(scl0_o),
    .idx1_v_o(idx1_v_o), .idx1_o(idx1_o), .scl1_o(scl1_o),
    .disp_o(disp_o), .dlg_v_o(dlg_v_o), .dlg_o(dlg_o), .dbl_o(dbl_o), .err_o(err_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R12";

  // Reference state
  logic [7:0] q[$];
  int e_done, e_op, e_bv, e_base, e_i0v, e_i0, e_s0, e_i1v, e_i1, e_s1;
  int e_disp, e_dv, e_dlg, e_dbl, e_err;

  task automatic clear_exp();
    e_done = 0; e_op = 0; e_bv = 0; e_base = 0; e_i0v = 0; e_i0 = 0; e_s0 = 0;
    e_i1v = 0; e_i1 = 0; e_s1 = 0; e_disp = 0; e_dv = 0; e_dlg = 0; e_dbl = 0; e_err = 0;
  endtask

  // Decodes a whole finished run from the byte queue.
  task automatic decode(input logic [7:0] opb);
    int i, d, r, nd;
    int ids[2];
    int scs[2];
    int cnt, last;
    clear_exp();
    ids[0] = 0; ids[1] = 0; scs[0] = 0; scs[1] = 0; cnt = 0; last = 0;
    e_done = 1; e_op = opb;
    i = 0;
    while (i + 1 < q.size() && q[i] == q[i+1]) begin
      d = q[i] >> 4;
      e_dv = 1;
      if (e_dlg * 10 + d > 999) e_err = 1; else e_dlg = e_dlg * 10 + d;
      i += 2;
    end
    if (i < q.size()) begin
      e_bv = 1; e_base = q[i] >> 4; e_disp = q[i] & 15; i++;
      for (int k = i; k < q.size(); k++) begin
        r = q[k] >> 4;
        nd = e_disp * 10 + (q[k] & 15);
        if (nd > 999999) e_err = 1; else e_disp = nd;
        if (r == e_base) begin
          if (cnt == 0) e_err = 1;
          else if (scs[last] < 15) scs[last]++;
        end else begin
          int hit = -1;
          for (int s = 0; s < cnt; s++) if (ids[s] == r) hit = s;
          if (hit >= 0) begin
            if (scs[hit] < 15) scs[hit]++;
            last = hit;
          end else if (cnt < 2) begin
            ids[cnt] = r; scs[cnt] = 1; last = cnt; cnt++;
          end else e_err = 1;
        end
      end
    end
    e_i0v = (cnt >= 1); e_i0 = ids[0]; e_s0 = scs[0];
    e_i1v = (cnt == 2); e_i1 = ids[1]; e_s1 = scs[1];
    e_dbl = e_dv && e_bv;
    q.delete();
  endtask

  task automatic model_step(input logic v, input logic [7:0] b);
    logic pre;
    e_done = 0;
    if (!v) return;
    pre = (b[7:4] >= 1) && (b[7:4] <= 9) && (b[3:0] <= 9);
    if (pre) q.push_back(b);
    else decode(b);
  endtask

  logic bad;
  task automatic fld(input string nm, input int act, input int exp);
    if (act != exp) begin
      bad = 1'b1;
      $display("FAIL %s field %s actual=%0d expected=%0d", cur_tag, nm, act, exp);
    end
  endtask

  task automatic compare();
    bad = 1'b0;
    n_cmp++;
    fld("done", done_o, e_done);  fld("op", op_o, e_op);
    fld("base_v", base_v_o, e_bv); fld("base", base_o, e_base);
    fld("idx0_v", idx0_v_o, e_i0v); fld("idx0", idx0_o, e_i0); fld("scl0", scl0_o, e_s0);
    fld("idx1_v", idx1_v_o, e_i1v); fld("idx1", idx1_o, e_i1); fld("scl1", scl1_o, e_s1);
    fld("disp", disp_o, e_disp); fld("dlg_v", dlg_v_o, e_dv); fld("dlg", dlg_o, e_dlg);
    fld("dbl", dbl_o, e_dbl); fld("err", err_o, e_err);
    if (bad) n_bad++;
  endtask

  // One cycle: check the state after the previous edge, then drive.
  task automatic cyc(input logic v, input logic [7:0] b);
    @(negedge clk);
    compare();
    in_valid = v; in_byte = b;
    model_step(v, b);
  endtask

  task automatic run(input string tag, input logic [7:0] bytes[$]);
    cur_tag = tag;
    foreach (bytes[k]) cyc(1'b1, bytes[k]);
    cyc(1'b0, 8'h00);
    cyc(1'b0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    n_bad++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s[$];
    clear_exp();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cur_tag = "R12";
    cyc(1'b0, 8'h00);                                  // R12 reset state
    run("R2", '{8'h10, 8'hA1});                         // R2 base only
    run("R3", '{8'h10, 8'h34, 8'h15, 8'h36, 8'hA1});    // R3 R6 disp 456, D3 x3
    run("R4", '{8'h14, 8'h35, 8'h86, 8'h37, 8'hB8});    // R4 two slots
    s = '{8'h10};
    for (int k = 0; k < 16; k++) s.push_back(8'h30);
    s.push_back(8'hC0);
    run("R5", s);                                       // R5 saturation at 15
    run("R6", '{8'h14, 8'h15, 8'hA1});                  // R6 base repeat, no index
    run("R7", '{8'h12, 8'h23, 8'h34, 8'h45, 8'hA1});    // R7 third index
    run("R8", '{8'h19, 8'h29, 8'h29, 8'h29, 8'h29, 8'h29, 8'h29, 8'hA1}); // R8
    run("R9", '{8'h70, 8'h70, 8'h90, 8'h90, 8'h2E});    // R9 R10 delegate 79
    run("R11", '{8'h90, 8'h90, 8'h45, 8'h6E});          // R11 double pointer
    run("R13", '{8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'hA1}); // R13
    run("R1", '{8'h00});                                // R1 lone operation byte
    run("R1", '{8'h12, 8'h1B});                         // R1 low nibble above 9
    cur_tag = "R12";                                    // R12 gaps inside a run
    cyc(1'b1, 8'h23); cyc(1'b0, 8'h00); cyc(1'b1, 8'h45);
    cyc(1'b0, 8'h00); cyc(1'b1, 8'hF0); cyc(1'b0, 8'h00);
    run("R1", '{8'hAA, 8'hAB});                         // R1 back-to-back terminators
    cyc(1'b0, 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule